// File: doc/BRIEF.md
# Time-Slot Switch Host Control Port

This block is the host-facing control port of a time-slot interchange switch. A parallel host bus with a 6-bit address, 8-bit data, chip select, read/write strobe and a ready return reaches one mode register and three per-channel memories. The memories are organised as 8 streams of 32 channels. The two connection memories (an "upper" word and a "lower" byte) are written by the host. The receive-data memory is filled by the switching side, and the host can only read it.

Host accesses are indirect. The mode register names the stream and the memory that every channel access hits, and it carries two global mode bits. One mode splits traffic so that channel reads come from receive data and channel writes go to the lower connection byte. The other forces every output channel into message mode by setting two bits of the upper connection word as it is presented to the output stage. A mode register access completes in the cycle it is presented. A memory access waits for a periodic internal memory slot. Toward the output stage the block presents, for the channel the stage asks for, the effective upper connection word, the message byte and a drive flag gated by an external output-enable pin.

Top module: `tsi_host_port`

## Requirements
- R1: With chip select high and address bit 5 at 0, the access hits the mode register whatever address bits 4..0 hold. Ready is high in that same cycle, a write takes effect at the next clock edge, and a read returns the register contents.
- R2: After reset the mode register is 0x00, all three memories read as zero, and ready is low while chip select is low.
- R3: With address bit 5 at 1, address bits 4..0 pick channel 0..31. The stream is mode bits 2..0, and the memory is mode bits 4..3: 01 receive data, 10 lower connection, 11 upper connection.
- R4: Ready stays low on a channel access until an internal memory slot is granted. Slots fall on the first clock edge after reset and every SLOT_CLKS edges after that. Ready rises in the cycle after the granting edge, so it comes within SLOT_CLKS+1 cycles, and it stays high until chip select drops.
- R5: With memory select 00 and split mode off, channel writes change nothing and channel reads return 0x00.
- R6: Host writes aimed at the receive-data memory change nothing.
- R7: With mode bit 7 set, channel reads return receive-data contents and channel writes go to the lower connection byte, whatever memory select holds.
- R8: With mode bit 6 set, the upper word presented to the output stage has bits 2 and 0 forced to 1, while the stored upper word read back by the host is unchanged.
- R9: The drive flag equals bit 0 of the effective upper word ANDed with the output-enable input, and it is 0 whenever that input is low.
- R10: The message output is the stored lower connection byte of the output stage's stream and channel. Switching-side writes store bytes in the receive-data memory at the given stream and channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_cs | input | 1 | Host chip select, held until ready |
| hst_rw | input | 1 | 1 = read, 0 = write |
| hst_addr | input | 6 | Host address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |
| hst_rdy | output | 1 | Access complete |
| sw_we | input | 1 | Switching-side receive-data write |
| sw_strm | input | 3 | Stream of switching-side write |
| sw_chan | input | 5 | Channel of switching-side write |
| sw_data | input | 8 | Received byte |
| out_strm | input | 3 | Output stage stream lookup |
| out_chan | input | 5 | Output stage channel lookup |
| ode | input | 1 | Output drive enable |
| out_hi | output | 8 | Effective upper connection word |
| out_msg | output | 8 | Lower connection byte (message) |
| out_drive | output | 1 | Channel output drive flag |

## Verification
The bench starts channel accesses at every phase of the slot cycle. A design that miscounted the slot wait would raise ready one cycle early or late, and one that dropped ready before chip select falls would break the hold rule. It aims writes at the receive-data memory, at select 00 and through split mode. A wrong design would then corrupt the receive byte, return stale data instead of zero, or write the wrong connection memory. With message mode on it reads the stored upper word back, which exposes a design that forces bits 2 and 0 in storage rather than only at the output. It also drops the output-enable pin with a forced channel active, so a design that lets message mode bypass the pin drives the output anyway.

// File: rtl/tsi_host_pkg.sv
package tsi_host_pkg;

    localparam int DATA_W = 8;
    localparam int CHAN_W = 5;
    localparam int STRM_W = 3;
    localparam int LOC_W  = STRM_W + CHAN_W;

    // Bits of the upper connection word forced while message mode is on
    localparam logic [DATA_W-1:0] MSG_FORCE = 8'h05;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_DM   = 2'b01,
        SEL_CML  = 2'b10,
        SEL_CMH  = 2'b11
    } mem_sel_e;

    typedef struct packed {
        logic                split;
        logic                msg;
        logic                spare;
        mem_sel_e            sel;
        logic [STRM_W-1:0]   strm;
    } ctrl_t;

    // Memory that a channel access reaches, given mode and direction
    function automatic mem_sel_e pick_target(ctrl_t c, logic is_read);
        if (c.split)
            return is_read ? SEL_DM : SEL_CML;
        return c.sel;
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer #(
    parameter int SLOT_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    output logic slot
);
    localparam int CW = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign slot = (cnt_q == '0);
endmodule

// File: rtl/tsi_ctrl_reg.sv
module tsi_ctrl_reg
    import tsi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/tsi_chan_mem.sv
module tsi_chan_mem #(
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end
endmodule

// File: rtl/tsi_host_port.sv
module tsi_host_port
    import tsi_host_pkg::*;
#(
    parameter int SLOT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_cs,
    input  logic              hst_rw,
    input  logic [5:0]        hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_rdy,
    input  logic              sw_we,
    input  logic [STRM_W-1:0] sw_strm,
    input  logic [CHAN_W-1:0] sw_chan,
    input  logic [DATA_W-1:0] sw_data,
    input  logic [STRM_W-1:0] out_strm,
    input  logic [CHAN_W-1:0] out_chan,
    input  logic              ode,
    output logic [DATA_W-1:0] out_hi,
    output logic [DATA_W-1:0] out_msg,
    output logic              out_drive
);
    ctrl_t              ctrl_q;
    logic               slot;
    logic               ctrl_hit, mem_hit, grant, done_q, msg_on;
    mem_sel_e           tgt;
    logic [LOC_W-1:0]   host_loc, out_loc;
    logic [DATA_W-1:0]  rd_sel, rd_q, eff_hi;
    logic [1:0][DATA_W-1:0] cml_rd, cmh_rd;
    logic [0:0][DATA_W-1:0] dm_rd;

    assign ctrl_hit = hst_cs & ~hst_addr[5];
    assign mem_hit  = hst_cs &  hst_addr[5];
    assign grant    = mem_hit & ~done_q & slot;
    assign tgt      = pick_target(ctrl_q, hst_rw);
    assign host_loc = {ctrl_q.strm, hst_addr[CHAN_W-1:0]};
    assign out_loc  = {out_strm, out_chan};
    assign msg_on   = ctrl_q.msg;

    tsi_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_slot (
        .clk(clk), .rst(rst), .slot(slot)
    );

    tsi_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_hit & ~hst_rw),
        .wdata(hst_wdata), .q(ctrl_q)
    );

    tsi_chan_mem #(.DW(DATA_W), .AW(LOC_W), .NRD(2)) u_cml (
        .clk(clk), .rst(rst),
        .we(grant & ~hst_rw & (tgt == SEL_CML)),
        .waddr(host_loc), .wdata(hst_wdata),
        .raddr({out_loc, host_loc}), .rdata(cml_rd)
    );

    tsi_chan_mem #(.DW(DATA_W), .AW(LOC_W), .NRD(2)) u_cmh (
        .clk(clk), .rst(rst),
        .we(grant & ~hst_rw & (tgt == SEL_CMH)),
        .waddr(host_loc), .wdata(hst_wdata),
        .raddr({out_loc, host_loc}), .rdata(cmh_rd)
    );

    tsi_chan_mem #(.DW(DATA_W), .AW(LOC_W), .NRD(1)) u_dm (
        .clk(clk), .rst(rst), .we(sw_we),
        .waddr({sw_strm, sw_chan}), .wdata(sw_data),
        .raddr(host_loc), .rdata(dm_rd)
    );

    always_comb begin
        unique case (tgt)
            SEL_DM:  rd_sel = dm_rd[0];
            SEL_CML: rd_sel = cml_rd[0];
            SEL_CMH: rd_sel = cmh_rd[0];
            default: rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            rd_q   <= '0;
        end else begin
            done_q <= mem_hit & (done_q | grant);
            if (grant & hst_rw)
                rd_q <= rd_sel;
        end
    end

    assign hst_rdy   = ctrl_hit | (mem_hit & done_q);
    assign hst_rdata = hst_addr[5] ? rd_q : DATA_W'(ctrl_q);

    assign eff_hi    = cmh_rd[1] | (msg_on ? MSG_FORCE : '0);
    assign out_hi    = eff_hi;
    assign out_msg   = cml_rd[1];
    assign out_drive = ode & eff_hi[0];
endmodule

// File: rtl/tsi_host_port_chk.sv
module tsi_host_port_chk #(
    parameter int SLOT_CLKS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic [5:0] addr,
    input logic       rdy,
    input logic       ode,
    input logic       drive,
    input logic [7:0] hi,
    input logic       msg
);
    logic [15:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst)
            wait_q <= '0;
        else if (cs & addr[5] & ~rdy)
            wait_q <= wait_q + 1'b1;
        else
            wait_q <= '0;
    end

    assert_ctrl_fast_R1: assert property (@(posedge clk) disable iff (rst)
        (cs & ~addr[5]) |-> rdy);

    assert_idle_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        ~cs |-> ~rdy);

    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (rst)
        wait_q <= 16'(SLOT_CLKS));

    assert_ready_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cs & addr[5] & rdy) |=> (~cs | rdy));

    assert_msg_force_R8: assert property (@(posedge clk) disable iff (rst)
        msg |-> (hi[2] & hi[0]));

    assert_ode_gate_R9: assert property (@(posedge clk) disable iff (rst)
        ~ode |-> ~drive);
endmodule

bind tsi_host_port tsi_host_port_chk #(.SLOT_CLKS(SLOT_CLKS)) u_chk (
    .clk(clk), .rst(rst), .cs(hst_cs), .addr(hst_addr), .rdy(hst_rdy),
    .ode(ode), .drive(out_drive), .hi(out_hi), .msg(msg_on)
);

// File: tb/tsi_host_port_test.sv
`timescale 1ns/1ps
module tsi_host_port_test;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hst_cs = 1'b0, hst_rw = 1'b0;
    logic [5:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic hst_rdy;
    logic sw_we = 1'b0;
    logic [2:0] sw_strm = '0;
    logic [4:0] sw_chan = '0;
    logic [7:0] sw_data = '0;
    logic [2:0] out_strm = '0;
    logic [4:0] out_chan = '0;
    logic ode = 1'b1;
    logic [7:0] out_hi, out_msg;
    logic out_drive;

    int n_cmp = 0, n_bad = 0, edge_n = 0;
    bit finished = 0;
    logic [7:0] m_dm [256];
    logic [7:0] m_cml[256];
    logic [7:0] m_cmh[256];
    logic [7:0] m_ctrl = 8'h00;

    always #2.5 clk = ~clk;

    tsi_host_port #(.SLOT_CLKS(P)) uut (.*);

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Output stage view compared every clock against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            automatic int a = {out_strm, out_chan};
            automatic logic [7:0] eh = m_cmh[a] | (m_ctrl[6] ? 8'h05 : 8'h00);
            check(out_hi == eh, "R8 out_hi", out_hi, eh);
            check(out_msg == m_cml[a], "R10 out_msg", out_msg, m_cml[a]);
            check(out_drive == (ode & eh[0]), "R9 out_drive", out_drive, ode & eh[0]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctrl_write(input logic [4:0] junk, input logic [7:0] v);
        @(negedge clk);
        hst_cs = 1; hst_rw = 0; hst_addr = {1'b0, junk}; hst_wdata = v;
        #1 check(hst_rdy == 1'b1, "R1 ctrl write ready", hst_rdy, 1);
        @(negedge clk);
        m_ctrl = v;
        hst_cs = 0;
    endtask

    task automatic ctrl_read(input logic [4:0] junk);
        @(negedge clk);
        hst_cs = 1; hst_rw = 1; hst_addr = {1'b0, junk};
        #1;
        check(hst_rdy == 1'b1, "R1 ctrl read ready", hst_rdy, 1);
        check(hst_rdata == m_ctrl, "R1 ctrl read data", hst_rdata, m_ctrl);
        @(negedge clk);
        hst_cs = 0;
    endtask

    task automatic sw_write(input int s, input int c, input logic [7:0] v);
        @(negedge clk);
        sw_we = 1; sw_strm = 3'(s); sw_chan = 5'(c); sw_data = v;
        @(negedge clk);
        sw_we = 0;
        m_dm[{s[2:0], c[4:0]}] = v;
    endtask

    // Channel access; returns read data, checks ready timing each cycle
    task automatic mem_access(input bit rd, input int c, input logic [7:0] v,
                              input string req, output logic [7:0] got);
        automatic int kg;
        automatic int a;
        automatic int tgt;
        automatic bit rdy_exp = 0;
        @(negedge clk);
        hst_cs = 1; hst_rw = rd; hst_addr = {1'b1, 5'(c)}; hst_wdata = v;
        kg = edge_n;
        while (kg % P != 0) kg++;
        for (int i = 0; i < 2 * P + 2 && !rdy_exp; i++) begin
            @(negedge clk);
            rdy_exp = (edge_n > kg);
            check(hst_rdy == rdy_exp, "R4 ready timing", hst_rdy, rdy_exp);
        end
        got = hst_rdata;
        hst_cs = 0;
        a = {m_ctrl[2:0], 5'(c)};
        tgt = m_ctrl[7] ? (rd ? 1 : 2) : int'(m_ctrl[4:3]);
        if (rd) begin
            automatic logic [7:0] e = (tgt == 1) ? m_dm[a] : (tgt == 2) ? m_cml[a] :
                                      (tgt == 3) ? m_cmh[a] : 8'h00;
            check(got == e, req, got, e);
        end else begin
            if (tgt == 2) m_cml[a] = v;
            if (tgt == 3) m_cmh[a] = v;
        end
        @(negedge clk);
    endtask

    task automatic rd_chk(input int c, input string req);
        logic [7:0] g;
        mem_access(1, c, 8'h00, req, g);
    endtask

    task automatic wr(input int c, input logic [7:0] v, input string req);
        logic [7:0] g;
        mem_access(0, c, v, req, g);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_dm[i] = 0; m_cml[i] = 0; m_cmh[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        #1 check(hst_rdy == 1'b0, "R2 ready low after reset", hst_rdy, 0);
        ctrl_read(5'h1F);                       // R2 reset value 0x00
        rd_chk(3, "R2 memory clear");

        // R1: register reached at any low address; sel CML (10), stream 3
        ctrl_write(5'h0A, 8'h13);
        ctrl_read(5'h1F);
        ctrl_read(5'h00);

        // R3 / R10: lower connection write and readback, output view
        wr(5, 8'hA5, "R3 cml write");
        idle(1);
        wr(31, 8'h3C, "R3 cml write ch31");
        rd_chk(5, "R3 cml read ch5");
        rd_chk(31, "R3 cml read ch31");
        out_strm = 3; out_chan = 5;
        idle(3);

        // R3 / R9: upper connection (sel 11), drive gated by ode
        ctrl_write(5'h01, 8'h1B);
        wr(5, 8'h01, "R3 cmh write");
        idle(2);
        rd_chk(5, "R3 cmh read");
        ode = 0; idle(2);
        ode = 1; idle(2);

        // R3 / R6 / R10: receive data (sel 01) filled from switching side
        sw_write(3, 7, 8'h77);
        ctrl_write(5'h02, 8'h0B);
        rd_chk(7, "R3 dm read");
        wr(7, 8'h11, "R6 dm write");
        rd_chk(7, "R6 dm unchanged");

        // R5: select 00 ignores writes, reads zero
        ctrl_write(5'h03, 8'h03);
        wr(5, 8'hFF, "R5 none write");
        rd_chk(5, "R5 none read zero");
        ctrl_write(5'h03, 8'h13);
        rd_chk(5, "R5 cml untouched");

        // R7: split mode, with select 00 and with select 11
        ctrl_write(5'h04, 8'h83);
        wr(9, 8'h42, "R7 split write");
        rd_chk(7, "R7 split read dm");
        ctrl_write(5'h04, 8'h9B);
        idle(1);
        wr(10, 8'h24, "R7 split write sel11");
        rd_chk(7, "R7 split read dm sel11");
        ctrl_write(5'h05, 8'h13);
        rd_chk(9, "R7 cml got split write");
        rd_chk(10, "R7 cml got split write 2");
        ctrl_write(5'h05, 8'h1B);
        rd_chk(10, "R7 cmh untouched");

        // R8 / R9: message mode forces bits at the output only
        ctrl_write(5'h06, 8'h5B);
        out_strm = 3; out_chan = 9;
        idle(2);
        rd_chk(9, "R8 stored cmh unchanged");
        ode = 0; idle(2);
        check(out_drive == 1'b0, "R9 ode low blocks message", out_drive, 0);
        ode = 1; idle(1);
        check(out_drive == 1'b1, "R9 forced drive", out_drive, 1);

        // Other stream, varied slot phases
        ctrl_write(5'h07, 8'h16);
        for (int k = 0; k < 6; k++) begin
            wr(k * 5, 8'(8'h30 + k), "R3 stream6 write");
            idle(k % 3);
        end
        for (int k = 0; k < 6; k++) rd_chk(k * 5, "R3 stream6 read");
        out_strm = 6; out_chan = 20;
        idle(2);
        ctrl_write(5'h07, 8'h00);
        idle(2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule